// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Chain

This block decides the unsigned ordering of two words. It reports whether the first operand is greater than, less than or equal to the second, on three separate outputs. It is built from identical 4-bit slices. Each slice forms a local verdict on its own bit pairs, where the most significant unequal pair wins. The slice then merges that verdict with a 3-wire relation handed up from the slice below it. The result is that the highest-order slice with differing operands decides the whole comparison.

The top level joins three slices into a 12-bit comparator. The lowest slice is seeded with the "equal" relation. The relation on the wires between slices is one-hot in normal use, with exactly one of greater, less and equal asserted. When a slice's own operands match, it forwards whatever pattern it receives without changing it, and it corrects nothing. The block is purely combinational.

Top module: `mcmp_chain`

## Requirements
- R1: `eq` is 1 exactly when `a` equals `b` over all 12 bits.
- R2: `gt` is 1 exactly when `a` is greater than `b` as unsigned numbers.
- R3: `lt` is 1 exactly when `a` is less than `b` as unsigned numbers.
- R4: At the top level, exactly one of `gt`, `lt`, `eq` is 1 for every input pair.
- R5: The most significant unequal bit pair decides the result, and bits below it have no effect. For example, 0x800 against 0x7FF gives `gt`=1.
- R6: A slice whose two 4-bit operands are equal drives its relation output identical to its relation input. This holds for non-one-hot patterns too. The relation is packed as bit 2 = greater, bit 1 = less, bit 0 = equal.
- R7: A slice whose operands differ outputs its own local verdict, 3'b100 for greater or 3'b010 for less. It ignores its relation input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 12 | First unsigned operand |
| b | input | 12 | Second unsigned operand |
| gt | output | 1 | 1 when a > b |
| lt | output | 1 | 1 when a < b |
| eq | output | 1 | 1 when a == b |

## Verification
Fixed corner pairs cover the following cases:
- All zeros and all ones.
- Opposite extremes.
- A difference only in the lowest bit.
- A difference only in the top bit, with the lower bits set against it. This case shows whether the bits below the deciding pair are really ignored.

Pairs that differ only inside one chosen slice, with the slices above held equal, show whether each link between slices carries its verdict upward. Several thousand random pairs, compared with integer ordering, catch wrong terms in the local equations.

A slice is also driven on its own with matched operands and one-hot, all-zero and multi-hot relation inputs, which shows the pass-through behaviour. The same slice driven with mismatched operands shows that a local decision overrides the input relation.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

  // Relation bundle: bit 2 greater, bit 1 less, bit 0 equal.
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } rel_t;

  localparam rel_t REL_SAME = 3'b001;

  // Equality of a single bit pair.
  function automatic logic bit_same(input logic x, input logic y);
    return ~(x ^ y);
  endfunction

  // Merge a local verdict with the relation coming from lower-order bits.
  function automatic rel_t fold(input rel_t loc, input rel_t cin);
    rel_t r;
    r.gt = loc.gt | (loc.eq & cin.gt);
    r.lt = loc.lt | (loc.eq & cin.lt);
    r.eq = loc.eq & cin.eq;
    return r;
  endfunction

endpackage

// File: rtl/mcmp_local.sv
module mcmp_local #(
  parameter int W = 4
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output mcmp_pkg::rel_t    rel
);
  import mcmp_pkg::*;

  logic [W-1:0] same;
  logic [W:0]   above;   // above[i]: every pair at index >= i matches
  logic [W-1:0] gt_term;
  logic [W-1:0] lt_term;

  assign above[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign same[i]    = bit_same(a[i], b[i]);
    assign above[i]   = above[i+1] & same[i];
    assign gt_term[i] = above[i+1] & a[i] & ~b[i];
    assign lt_term[i] = above[i+1] & ~a[i] & b[i];
  end

  always_comb begin
    rel.gt = |gt_term;
    rel.lt = |lt_term;
    rel.eq = above[0];
  end

endmodule

// File: rtl/mcmp_slice.sv
module mcmp_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  mcmp_pkg::rel_t    cin,
  output mcmp_pkg::rel_t    cout
);
  import mcmp_pkg::*;

  rel_t local_rel;

  mcmp_local #(.W(W)) u_local (
    .a  (a),
    .b  (b),
    .rel(local_rel)
  );

  assign cout = fold(local_rel, cin);

endmodule

// File: rtl/mcmp_chain.sv
module mcmp_chain #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 3
) (
  input  logic [SLICE_W*N_SLICES-1:0] a,
  input  logic [SLICE_W*N_SLICES-1:0] b,
  output logic                        gt,
  output logic                        lt,
  output logic                        eq
);
  import mcmp_pkg::*;

  localparam int W = SLICE_W * N_SLICES;

  rel_t link [N_SLICES+1];

  assign link[0] = REL_SAME;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    mcmp_slice #(.W(SLICE_W)) u_slice (
      .a   (a[s*SLICE_W +: SLICE_W]),
      .b   (b[s*SLICE_W +: SLICE_W]),
      .cin (link[s]),
      .cout(link[s+1])
    );
  end

  assign gt = link[N_SLICES].gt;
  assign lt = link[N_SLICES].lt;
  assign eq = link[N_SLICES].eq;

endmodule

// File: rtl/mcmp_chain_chk.sv
module mcmp_chain_chk #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 3
) (
  input logic [SLICE_W*N_SLICES-1:0] a,
  input logic [SLICE_W*N_SLICES-1:0] b,
  input logic                        gt,
  input logic                        lt,
  input logic                        eq
);
  localparam int W = SLICE_W * N_SLICES;

  logic [SLICE_W-1:0] a_hi;
  logic [SLICE_W-1:0] b_hi;
  assign a_hi = a[W-1 -: SLICE_W];
  assign b_hi = b[W-1 -: SLICE_W];

  always_comb begin
    p_eq_r1: assert (eq == (a == b)) else $error("R1 eq mismatch");
    p_gt_r2: assert (gt == (a > b)) else $error("R2 gt mismatch");
    p_lt_r3: assert (lt == (a < b)) else $error("R3 lt mismatch");
    p_onehot_r4: assert ($onehot({gt, lt, eq})) else $error("R4 not one-hot");
    if (a_hi != b_hi) begin
      p_top_decides_r5: assert (gt == (a_hi > b_hi)) else $error("R5 top slice ignored");
    end
  end

endmodule

bind mcmp_chain mcmp_chain_chk #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) u_chk (.*);

// File: tb/test_mcmp_chain.sv
module test_mcmp_chain;
  import mcmp_pkg::*;

  localparam int SW = 4;
  localparam int NS = 3;
  localparam int W  = SW * NS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic gt, lt, eq;

  mcmp_chain #(.SLICE_W(SW), .N_SLICES(NS)) i_mcmp_chain (
    .a(a), .b(b), .gt(gt), .lt(lt), .eq(eq)
  );

  logic [SW-1:0] sa = '0;
  logic [SW-1:0] sb = '0;
  rel_t scin = 3'b001;
  rel_t scout;

  mcmp_slice #(.W(SW)) i_slice (.a(sa), .b(sb), .cin(scin), .cout(scout));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [2:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one pair just after a rising edge, check at the following falling edge.
  task automatic run(input logic [W-1:0] av, input logic [W-1:0] bv, input string tag);
    int ia, ib;
    logic [2:0] e;
    @(posedge clk);
    #1;
    a = av;
    b = bv;
    ia = int'(av);
    ib = int'(bv);
    exp_q.push_back({ia > ib, ia < ib, ia == ib});
    @(negedge clk);
    e = exp_q.pop_front();
    chk({tag, " R2 gt"}, 32'(gt), 32'(e[2]));
    chk({tag, " R3 lt"}, 32'(lt), 32'(e[1]));
    chk({tag, " R1 eq"}, 32'(eq), 32'(e[0]));
    chk({tag, " R4 onehot"}, 32'(32'(gt) + 32'(lt) + 32'(eq)), 32'd1);
  endtask

  task automatic slice_run(input logic [SW-1:0] x, input logic [SW-1:0] y,
                           input rel_t ci, input rel_t expd, input string req);
    @(posedge clk);
    #1;
    sa = x;
    sb = y;
    scin = ci;
    @(negedge clk);
    chk(req, 32'(scout), 32'(expd));
  endtask

  initial begin
    @(negedge clk);
    chk("R1 initial eq", 32'(eq), 32'd1);
    run(12'h000, 12'h000, "zero");
    run(12'hFFF, 12'hFFF, "ones");
    run(12'hFFF, 12'h000, "max_min");
    run(12'h000, 12'hFFF, "min_max");
    run(12'h001, 12'h000, "lsb_gt");
    run(12'h000, 12'h001, "lsb_lt");
    run(12'h800, 12'h7FF, "R5 msb_gt");
    chk("R5 msb gt", 32'(gt), 32'd1);
    run(12'h7FF, 12'h800, "R5 msb_lt");
    chk("R5 msb lt", 32'(lt), 32'd1);
    for (int s = 0; s < NS; s++) begin
      for (int k = 0; k < 20; k++) begin
        logic [W-1:0] base;
        logic [SW-1:0] p, q;
        base = W'($urandom);
        p = SW'($urandom);
        q = SW'($urandom);
        run((base & ~(W'(4'hF) << (s*SW))) | (W'(p) << (s*SW)),
            (base & ~(W'(4'hF) << (s*SW))) | (W'(q) << (s*SW)), "R5 slice_local");
      end
    end
    for (int k = 0; k < 3000; k++) begin
      run(W'($urandom), W'($urandom), "random");
    end
    // Slice pass-through with equal operands.
    slice_run(4'h9, 4'h9, 3'b100, 3'b100, "R6 pass gt");
    slice_run(4'h9, 4'h9, 3'b010, 3'b010, "R6 pass lt");
    slice_run(4'h0, 4'h0, 3'b110, 3'b110, "R6 pass multi-hot");
    slice_run(4'hF, 4'hF, 3'b000, 3'b000, "R6 pass none");
    slice_run(4'h3, 4'h3, 3'b111, 3'b111, "R6 pass all");
    // Local decision overrides cascade.
    slice_run(4'h5, 4'h3, 3'b010, 3'b100, "R7 local gt");
    slice_run(4'h3, 4'h5, 3'b100, 3'b010, "R7 local lt");
    slice_run(4'h8, 4'h7, 3'b111, 3'b100, "R7 local gt over all");
    slice_run(4'h0, 4'h1, 3'b000, 3'b010, "R7 local lt over none");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule